// File: doc/BRIEF.md
# Transfer Descriptor Post-Move Update Unit

This block sits in a descriptor-driven transfer controller and runs once per completed data move. It takes the loaded descriptor as it stands: a mode byte, the transfer mode, the element size, the destination address, the area base address and the transfer counter. From these it computes the descriptor's next state: the new destination address and counter, with a write-back enable for each. It also makes the per-move control decisions: whether to interrupt the CPU, whether to chain to the next descriptor, and how an index-table sequence should proceed.

A move is reported with a one-cycle `done_i` strobe. All results are registered and appear with `valid_o` one cycle later. They stay valid, and `busy_o` stays high, until `ack_i` consumes them. A strobe that arrives while the block is busy is dropped. Source-address arithmetic stays with the bus master. This block only signals, through `src_reload_o`, that the source side must be reloaded.

Mode byte layout, as the block decodes it:

| Bits | Field | Meaning |
|------|-------|---------|
| [1:0] | destination mode | addressing mode for the destination |
| [2] | area side | 0 = destination, 1 = source |
| [3] | interrupt on each move | |
| [4] | chain enable | |
| [5] | chain on last only | |
| [6] | index-reference | |
| [7] | sequence-end | |

Transfer mode encoding: 00 = normal, 01 = repeat, 10 = block, 11 = reserved.

Top module: `dtu_post_update`

## Requirements
- R1: An accepted `done_i` (one seen while `busy_o` is low) yields `valid_o`=1 and `busy_o`=1 on the next cycle. The outputs then hold unchanged until `ack_i`. A `done_i` seen while busy is ignored.
- R2: Destination mode 00 or 01 leaves `dst_o` equal to the input destination, and `dst_wb_o` is 0 unless the area reload of R6/R7 replaces the destination.
- R3: Destination mode 10 gives `dst_o` = destination + 1, 2 or 4 for size 00, 01 or 10, with `dst_wb_o`=1.
- R4: Destination mode 11 gives `dst_o` = destination − 1, 2 or 4 for size 00, 01 or 10, with `dst_wb_o`=1.
- R5: In normal mode (00), `cnt_o` = counter − 1 modulo 2^16. A start value of 0 gives 0xFFFF, which means 65536 moves. The last move is the one where the counter goes from 1 to 0. `cnt_wb_o`=1.
- R6: In repeat mode (01), the low byte of the counter counts down while the high byte holds the reload value. When the low byte is 1, it is reloaded from the high byte and the area side is reloaded; that move is the last one. A reload of the destination side makes `dst_o` = `area_base_i` with `dst_wb_o`=1. A reload of the source side raises `src_reload_o` instead.
- R7: In block mode (10), the counter behaves as in R5, and the area side is reloaded on every move in the same way as in R6.
- R8: `irq_o` is 1 on every move when the interrupt-on-each bit (bit 3) is 1. Otherwise it is 1 only on the last move.
- R9: `chain_o` is 0 when chain enable (bit 4) is 0. With chain enable set, it is 1 on every move when bit 5 is 0, and only on the last move when bit 5 is 1.
- R10: `seq_start_o` follows the index-reference bit (bit 6). `seq_end_o` is the sequence-end bit (bit 7) when `via_index_i` is 1, and is 0 when `via_index_i` is 0.
- R11: `cfg_err_o` is 1 in three cases: size 11, transfer mode 11, or index-reference set in a non-normal mode. In that case `dst_o` and `cnt_o` equal their inputs, and all write-back enables, `irq_o`, `chain_o`, `src_reload_o` and the sequence outputs are 0.
- R12: After reset, `valid_o`, `busy_o` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| done_i | input | 1 | move-completed strobe |
| ack_i | input | 1 | results consumed |
| mode_i | input | 8 | descriptor mode byte |
| xfer_mode_i | input | 2 | transfer mode |
| size_i | input | 2 | element size code |
| via_index_i | input | 1 | descriptor was reached through the index table |
| dst_i | input | ADDR_W | current destination address |
| area_base_i | input | ADDR_W | reload address of the repeat/block area |
| cnt_i | input | CNT_W | current transfer counter |
| valid_o | output | 1 | results valid |
| busy_o | output | 1 | holding results, new strobes dropped |
| dst_o | output | ADDR_W | next destination address |
| cnt_o | output | CNT_W | next counter value |
| dst_wb_o | output | 1 | write destination back |
| cnt_wb_o | output | 1 | write counter back |
| src_reload_o | output | 1 | source side must be reloaded |
| irq_o | output | 1 | CPU interrupt request |
| chain_o | output | 1 | continue with the chained descriptor |
| seq_start_o | output | 1 | start an index-table sequence |
| seq_end_o | output | 1 | end the index-table sequence |
| cfg_err_o | output | 1 | illegal descriptor configuration |

## Verification
The bound checker covers a set of behaviours on every cycle:
- held results stay stable while unacknowledged;
- a configuration error suppresses every action;
- fixed and incrementing destination modes in normal mode produce the right address;
- an interrupt is raised for each move when that is selected;
- chaining is absent when disabled.

Three behaviours depend on specific counter values and reload boundaries, so only the directed scenarios show them: the 1→0 and 1→reload last-move detection, the 65536-move wrap, and the repeat- and block-area reloads on either side.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  typedef enum logic [1:0] {
    XM_NORMAL = 2'b00,
    XM_REPEAT = 2'b01,
    XM_BLOCK  = 2'b10,
    XM_RSVD   = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    DM_FIX0 = 2'b00,
    DM_FIX1 = 2'b01,
    DM_INC  = 2'b10,
    DM_DEC  = 2'b11
  } dst_mode_e;

  typedef struct packed {
    logic      seq_end;
    logic      idx_ref;
    logic      chain_last;
    logic      chain_en;
    logic      irq_each;
    logic      area_src;
    dst_mode_e dst_mode;
  } mode_t;

  localparam logic [1:0] SIZE_RSVD = 2'b11;
endpackage

// File: rtl/dtu_dst_step.sv
module dtu_dst_step
  import dtu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [ADDR_W-1:0] base_i,
  input  dst_mode_e         dst_mode_i,
  input  logic [1:0]        size_i,
  input  logic              reload_i,
  output logic [ADDR_W-1:0] dst_o,
  output logic              wb_o
);
  localparam int STEP_W = 3;
  logic [ADDR_W-1:0] step;

  always_comb begin
    step = '0;
    step[STEP_W-1:0] = STEP_W'(1) << size_i;
  end

  always_comb begin
    dst_o = dst_i;
    wb_o  = 1'b0;
    if (reload_i) begin
      dst_o = base_i;
      wb_o  = 1'b1;
    end else begin
      unique case (dst_mode_i)
        DM_INC: begin dst_o = dst_i + step; wb_o = 1'b1; end
        DM_DEC: begin dst_o = dst_i - step; wb_o = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dtu_cnt_step.sv
module dtu_cnt_step
  import dtu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  xfer_mode_e       xm_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic             area_reload_o
);
  localparam int HALF_W = CNT_W / 2;

  logic [HALF_W-1:0] lo, hi, lo_next;
  logic              lo_last;

  generate
    if (CNT_W % 2 != 0) begin : g_bad_width
      initial $error("CNT_W must be even");
    end
  endgenerate

  assign lo      = cnt_i[HALF_W-1:0];
  assign hi      = cnt_i[CNT_W-1:HALF_W];
  assign lo_last = (lo == HALF_W'(1));
  assign lo_next = lo_last ? hi : lo - HALF_W'(1);

  always_comb begin
    cnt_o         = cnt_i - CNT_W'(1);
    last_o        = (cnt_i == CNT_W'(1));
    area_reload_o = 1'b0;
    unique case (xm_i)
      XM_REPEAT: begin
        cnt_o         = {hi, lo_next};
        last_o        = lo_last;
        area_reload_o = lo_last;
      end
      XM_BLOCK: area_reload_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/dtu_ctrl.sv
module dtu_ctrl
  import dtu_pkg::*;
(
  input  mode_t mode_i,
  input  logic  last_i,
  input  logic  via_index_i,
  output logic  irq_o,
  output logic  chain_o,
  output logic  seq_start_o,
  output logic  seq_end_o
);
  assign irq_o       = mode_i.irq_each | last_i;
  assign chain_o     = mode_i.chain_en & (~mode_i.chain_last | last_i);
  assign seq_start_o = mode_i.idx_ref;
  // sequence-end only meaningful for index-table descriptors
  assign seq_end_o   = mode_i.seq_end & via_index_i;
endmodule

// File: rtl/dtu_post_update.sv
module dtu_post_update
  import dtu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              ack_i,
  input  logic [7:0]        mode_i,
  input  logic [1:0]        xfer_mode_i,
  input  logic [1:0]        size_i,
  input  logic              via_index_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [ADDR_W-1:0] area_base_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              valid_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              dst_wb_o,
  output logic              cnt_wb_o,
  output logic              src_reload_o,
  output logic              irq_o,
  output logic              chain_o,
  output logic              seq_start_o,
  output logic              seq_end_o,
  output logic              cfg_err_o
);
  mode_t             mode;
  xfer_mode_e        xm;
  logic              accept, cfg_err;
  logic              last, area_reload, dst_reload;
  logic [ADDR_W-1:0] dst_next;
  logic              dst_wb;
  logic [CNT_W-1:0]  cnt_next;
  logic              irq, chain, seq_start, seq_end;

  assign mode    = mode_t'(mode_i);
  assign xm      = xfer_mode_e'(xfer_mode_i);
  assign accept  = done_i & ~valid_o;
  assign cfg_err = (size_i == SIZE_RSVD) || (xm == XM_RSVD) ||
                   (mode.idx_ref && xm != XM_NORMAL);

  dtu_cnt_step #(.CNT_W(CNT_W)) u_cnt (
    .xm_i          (xm),
    .cnt_i         (cnt_i),
    .cnt_o         (cnt_next),
    .last_o        (last),
    .area_reload_o (area_reload)
  );

  assign dst_reload = area_reload & ~mode.area_src;

  dtu_dst_step #(.ADDR_W(ADDR_W)) u_dst (
    .dst_i      (dst_i),
    .base_i     (area_base_i),
    .dst_mode_i (mode.dst_mode),
    .size_i     (size_i),
    .reload_i   (dst_reload),
    .dst_o      (dst_next),
    .wb_o       (dst_wb)
  );

  dtu_ctrl u_ctrl (
    .mode_i      (mode),
    .last_i      (last),
    .via_index_i (via_index_i),
    .irq_o       (irq),
    .chain_o     (chain),
    .seq_start_o (seq_start),
    .seq_end_o   (seq_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      dst_o        <= '0;
      cnt_o        <= '0;
      dst_wb_o     <= 1'b0;
      cnt_wb_o     <= 1'b0;
      src_reload_o <= 1'b0;
      irq_o        <= 1'b0;
      chain_o      <= 1'b0;
      seq_start_o  <= 1'b0;
      seq_end_o    <= 1'b0;
      cfg_err_o    <= 1'b0;
    end else if (accept) begin
      valid_o      <= 1'b1;
      cfg_err_o    <= cfg_err;
      dst_o        <= cfg_err ? dst_i : dst_next;
      cnt_o        <= cfg_err ? cnt_i : cnt_next;
      dst_wb_o     <= ~cfg_err & dst_wb;
      cnt_wb_o     <= ~cfg_err;
      src_reload_o <= ~cfg_err & area_reload & mode.area_src;
      irq_o        <= ~cfg_err & irq;
      chain_o      <= ~cfg_err & chain;
      seq_start_o  <= ~cfg_err & seq_start;
      seq_end_o    <= ~cfg_err & seq_end;
    end else if (ack_i) begin
      valid_o <= 1'b0;
    end
  end

  assign busy_o = valid_o;
endmodule

// File: rtl/dtu_post_update_chk.sv
module dtu_post_update_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_i,
  input logic              ack_i,
  input logic [7:0]        mode_i,
  input logic [1:0]        xfer_mode_i,
  input logic [1:0]        size_i,
  input logic [ADDR_W-1:0] dst_i,
  input logic              valid_o,
  input logic              busy_o,
  input logic [ADDR_W-1:0] dst_o,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              dst_wb_o,
  input logic              cnt_wb_o,
  input logic              irq_o,
  input logic              chain_o,
  input logic              cfg_err_o
);
  logic acc, bad;
  assign acc = done_i && !busy_o;
  assign bad = (size_i == 2'b11) || (xfer_mode_i == 2'b11) ||
               (mode_i[6] && xfer_mode_i != 2'b00);

  a_r1_valid_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> valid_o);

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ack_i) |=> (valid_o && $stable(dst_o) && $stable(cnt_o) && $stable(irq_o)));

  a_r2_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !bad && xfer_mode_i == 2'b00 && !mode_i[1]) |=> (dst_o == $past(dst_i) && !dst_wb_o));

  a_r3_inc_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && xfer_mode_i == 2'b00 && mode_i[1:0] == 2'b10 && size_i == 2'b00 && !mode_i[6])
      |=> (dst_o == $past(dst_i) + ADDR_W'(1)));

  a_r8_irq_each: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !bad && mode_i[3]) |=> irq_o);

  a_r9_no_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !mode_i[4]) |=> !chain_o);

  a_r11_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cfg_err_o) |-> (!irq_o && !chain_o && !dst_wb_o && !cnt_wb_o));
endmodule

bind dtu_post_update dtu_post_update_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_i      (done_i),
  .ack_i       (ack_i),
  .mode_i      (mode_i),
  .xfer_mode_i (xfer_mode_i),
  .size_i      (size_i),
  .dst_i       (dst_i),
  .valid_o     (valid_o),
  .busy_o      (busy_o),
  .dst_o       (dst_o),
  .cnt_o       (cnt_o),
  .dst_wb_o    (dst_wb_o),
  .cnt_wb_o    (cnt_wb_o),
  .irq_o       (irq_o),
  .chain_o     (chain_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/dtu_post_update_tb_top.sv
module dtu_post_update_tb_top;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          done = 1'b0, ack = 1'b0;
  logic [7:0]    mode = '0;
  logic [1:0]    xm = '0, size = '0;
  logic          via = 1'b0;
  logic [AW-1:0] dst = '0, base = '0;
  logic [CW-1:0] cnt = '0;
  logic          valid, busy, dst_wb, cnt_wb, src_rl, irq, chain, sq_s, sq_e, cerr;
  logic [AW-1:0] dst_q;
  logic [CW-1:0] cnt_q;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  dtu_post_update #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .done_i(done), .ack_i(ack),
    .mode_i(mode), .xfer_mode_i(xm), .size_i(size), .via_index_i(via),
    .dst_i(dst), .area_base_i(base), .cnt_i(cnt),
    .valid_o(valid), .busy_o(busy), .dst_o(dst_q), .cnt_o(cnt_q),
    .dst_wb_o(dst_wb), .cnt_wb_o(cnt_wb), .src_reload_o(src_rl),
    .irq_o(irq), .chain_o(chain), .seq_start_o(sq_s), .seq_end_o(sq_e),
    .cfg_err_o(cerr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode byte: {seq_end, idx_ref, chain_last, chain_en, irq_each, area_src, dst_mode[1:0]}
  task automatic run(input logic [7:0] m, input logic [1:0] x, input logic [1:0] s,
                     input logic v, input logic [AW-1:0] d, input logic [AW-1:0] b,
                     input logic [CW-1:0] c);
    @(negedge clk);
    mode = m; xm = x; size = s; via = v; dst = d; base = b; cnt = c; done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic consume();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 valid", valid, 0); chk("R12 busy", busy, 0);
    chk("R12 dst", dst_q, 0); chk("R12 cnt", cnt_q, 0);
    chk("R12 flags", {dst_wb, cnt_wb, src_rl, irq, chain, sq_s, sq_e, cerr}, 0);
  endtask

  task automatic t_fixed();
    run(8'h00, 2'b00, 2'b10, 0, 32'h1000, 32'h0, 16'd5);
    chk("R1 valid", valid, 1); chk("R1 busy", busy, 1);
    chk("R2 dst mode00", dst_q, 32'h1000); chk("R2 wb", dst_wb, 0);
    consume();
    chk("R1 ack clears", valid, 0);
    run(8'h01, 2'b00, 2'b00, 0, 32'h2000, 32'h0, 16'd5);
    chk("R2 dst mode01", dst_q, 32'h2000); chk("R2 wb01", dst_wb, 0);
    consume();
  endtask

  task automatic t_inc();
    for (int s = 0; s < 3; s++) begin
      run(8'h02, 2'b00, 2'(s), 0, 32'h100, 32'h0, 16'd9);
      chk("R3 inc", dst_q, 32'h100 + (32'd1 << s)); chk("R3 wb", dst_wb, 1);
      consume();
    end
  endtask

  task automatic t_dec();
    for (int s = 0; s < 3; s++) begin
      run(8'h03, 2'b00, 2'(s), 0, 32'h100, 32'h0, 16'd9);
      chk("R4 dec", dst_q, 32'h100 - (32'd1 << s)); chk("R4 wb", dst_wb, 1);
      consume();
    end
    run(8'h03, 2'b00, 2'b10, 0, 32'h2, 32'h0, 16'd9);
    chk("R4 dec wrap", dst_q, 32'hFFFF_FFFE);
    consume();
  endtask

  task automatic t_normal_cnt();
    run(8'h00, 2'b00, 2'b00, 0, 32'h0, 32'h0, 16'd0);
    chk("R5 zero start", cnt_q, 16'hFFFF); chk("R5 cnt wb", cnt_wb, 1);
    chk("R8 not last no irq", irq, 0);
    consume();
    run(8'h00, 2'b00, 2'b00, 0, 32'h0, 32'h0, 16'd1);
    chk("R5 last", cnt_q, 16'h0000); chk("R8 irq on last", irq, 1);
    consume();
    run(8'h00, 2'b00, 2'b00, 0, 32'h0, 32'h0, 16'd7);
    chk("R5 dec", cnt_q, 16'd6); chk("R8 mid no irq", irq, 0);
    consume();
  endtask

  task automatic t_repeat();
    run(8'h02, 2'b01, 2'b00, 0, 32'h40, 32'h80, 16'h0503);
    chk("R6 lo dec", cnt_q, 16'h0502); chk("R6 dst advances", dst_q, 32'h41);
    chk("R6 no irq", irq, 0);
    consume();
    run(8'h02, 2'b01, 2'b00, 0, 32'h44, 32'h80, 16'h0501);
    chk("R6 reload cnt", cnt_q, 16'h0505); chk("R6 reload dst", dst_q, 32'h80);
    chk("R6 dst wb", dst_wb, 1); chk("R6 irq last", irq, 1); chk("R6 no src", src_rl, 0);
    consume();
    run(8'h04, 2'b01, 2'b00, 0, 32'h44, 32'h80, 16'h0501);
    chk("R6 src reload", src_rl, 1); chk("R6 dst kept", dst_q, 32'h44);
    chk("R6 dst no wb", dst_wb, 0);
    consume();
  endtask

  task automatic t_block();
    run(8'h00, 2'b10, 2'b01, 0, 32'h300, 32'h200, 16'd3);
    chk("R7 cnt", cnt_q, 16'd2); chk("R7 dst reload", dst_q, 32'h200);
    chk("R7 wb", dst_wb, 1); chk("R7 no irq", irq, 0);
    consume();
    run(8'h06, 2'b10, 2'b01, 0, 32'h300, 32'h200, 16'd1);
    chk("R7 src reload", src_rl, 1); chk("R7 dst inc", dst_q, 32'h302);
    chk("R7 last cnt", cnt_q, 16'd0); chk("R7 irq last", irq, 1);
    consume();
  endtask

  task automatic t_irq_chain();
    run(8'h08, 2'b00, 2'b00, 0, 32'h0, 32'h0, 16'd9);
    chk("R8 irq each", irq, 1); chk("R9 chain off", chain, 0);
    consume();
    run(8'h10, 2'b00, 2'b00, 0, 32'h0, 32'h0, 16'd9);
    chk("R9 chain every", chain, 1);
    consume();
    run(8'h30, 2'b00, 2'b00, 0, 32'h0, 32'h0, 16'd9);
    chk("R9 chain last only mid", chain, 0);
    consume();
    run(8'h30, 2'b00, 2'b00, 0, 32'h0, 32'h0, 16'd1);
    chk("R9 chain last only end", chain, 1);
    consume();
    run(8'h30, 2'b01, 2'b00, 0, 32'h0, 32'h0, 16'h0301);
    chk("R9 chain on reload", chain, 1);
    consume();
  endtask

  task automatic t_seq();
    run(8'hC0, 2'b00, 2'b00, 1, 32'h0, 32'h0, 16'd4);
    chk("R10 start", sq_s, 1); chk("R10 end via index", sq_e, 1);
    consume();
    run(8'h80, 2'b00, 2'b00, 0, 32'h0, 32'h0, 16'd4);
    chk("R10 end ignored", sq_e, 0); chk("R10 no start", sq_s, 0);
    consume();
  endtask

  task automatic t_cfg();
    run(8'h1A, 2'b00, 2'b11, 0, 32'h500, 32'h0, 16'd1);
    chk("R11 size err", cerr, 1); chk("R11 dst same", dst_q, 32'h500);
    chk("R11 cnt same", cnt_q, 16'd1);
    chk("R11 quiet", {dst_wb, cnt_wb, irq, chain, src_rl}, 0);
    consume();
    run(8'h40, 2'b01, 2'b00, 0, 32'h0, 32'h0, 16'd2);
    chk("R11 idx non-normal", cerr, 1); chk("R11 no seq", sq_s, 0);
    consume();
    run(8'h00, 2'b11, 2'b00, 0, 32'h0, 32'h0, 16'd2);
    chk("R11 rsvd mode", cerr, 1);
    consume();
    run(8'h00, 2'b00, 2'b00, 0, 32'h0, 32'h0, 16'd2);
    chk("R11 clean", cerr, 0);
    consume();
  endtask

  task automatic t_busy();
    run(8'h02, 2'b00, 2'b00, 0, 32'h10, 32'h0, 16'd5);
    @(negedge clk);
    mode = 8'h03; dst = 32'h99; cnt = 16'd1; done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R1 busy ignore dst", dst_q, 32'h11); chk("R1 busy ignore cnt", cnt_q, 16'd4);
    chk("R1 still valid", valid, 1);
    consume();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_fixed();
    t_inc();
    t_dec();
    t_normal_cnt();
    t_repeat();
    t_block();
    t_irq_chain();
    t_seq();
    t_cfg();
    t_busy();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule